// File: doc/BRIEF.md
# Windowed Display RAM Write Address Generator

This block turns a stream of decoded host commands and pixel strobes into write addresses for a square display memory of 132 by 132 pixels. The host first fences off a rectangle of the memory with two window commands, one for the column range and one for the page (row) range. Each window command carries two parameter bytes: the first is the lower bound and the second is the upper bound. A memory-write command then starts a burst. Every pixel strobe in that burst is stored at the current position, and the position steps through the rectangle by itself, wrapping at the edges of the window.

A direction flag chooses which axis moves fastest: the column axis or the page axis. Two mirror flags reflect the physical column or row address across the memory. Any command other than memory-write ends the burst. The memory-write command always rewinds both pointers to the window's lower corner. The block drives a registered column address, row address and write enable toward the memory. The memory itself is outside this block, so its contents do not depend on this block's reset.

Top module: `wag_top`

## Requirements
- R1: After reset the column window and the page window are both 2..129, the write enable is low, and write mode is off. Pixel strobes are ignored until a memory-write command arrives, and the first pixel after that command goes to column 2, row 2.
- R2: Command code 0x2A followed by two parameter bytes (lower bound first, then upper bound) replaces the column window. The new window is taken only if the lower bound is strictly below the upper bound and the upper bound is at most 131. Otherwise the old window is kept.
- R3: Command code 0x2B sets the page window in the same way, under the same acceptance rule.
- R4: Command code 0x2C returns the column pointer and the page pointer to their window lower bounds and enters write mode. In write mode each pixel strobe causes exactly one write: the write enable is high, with that pixel's address, in the cycle after the strobe.
- R5: With the direction flag at 0, the column advances at every pixel. A column at its upper bound returns to its lower bound and the page advances. A page at its upper bound returns to its lower bound.
- R6: With the direction flag at 1, the page axis advances at every pixel, and the column axis advances only when the page wraps. Both axes wrap as described in R5.
- R7: Any command other than 0x2C, including 0x00, ends write mode. Pixel strobes that follow produce no write until the next 0x2C.
- R8: A command and a pixel strobe in the same cycle: the command takes effect and the pixel is dropped, with no write.
- R9: With the column mirror flag set, the column address output is 131 minus the logical column. With the row mirror flag set, the row address output is 131 minus the logical page.
- R10: A window command cut short by another command before its second parameter byte changes no window. Parameter bytes received outside a window command are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdCode | input | 8 | Command byte |
| parmValid | input | 1 | Parameter byte strobe |
| parmData | input | 8 | Parameter byte |
| pixValid | input | 1 | Pixel word strobe |
| dirPageFirst | input | 1 | 0: column advances first, 1: page advances first |
| mirrorCol | input | 1 | Reflect column address |
| mirrorRow | input | 1 | Reflect row address |
| ramCol | output | 8 | Physical column address of the write |
| ramRow | output | 8 | Physical row address of the write |
| ramWe | output | 1 | Write enable, one cycle per stored pixel |

## Verification
A command and a pixel strobe can arrive in the same cycle. The command then wins, and this holds both for a NOP that ends the burst and for a memory-write command that rewinds it. The bench drives both strobes on the same falling edge. It then checks that the write enable stays low in the following cycle, and that the next lone pixel lands either nowhere (after the NOP) or at the window's lower corner (after the rewind). The window walk is swept over several window shapes, both directions and all four mirror settings, with every address computed arithmetically from the pixel index.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [7:0] OP_COL_WIN  = 8'h2A;
  localparam logic [7:0] OP_PAGE_WIN = 8'h2B;
  localparam logic [7:0] OP_MEM_WR   = 8'h2C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COL_A,
    ST_COL_B,
    ST_PAGE_A,
    ST_PAGE_B,
    ST_WRITE
  } ctrlState_e;

  // strobes from control to datapath; loadWin[0] = column, loadWin[1] = page
  typedef struct packed {
    logic [1:0]        loadWin;
    logic              rewind;
    logic              step;
    logic [ADDR_W-1:0] winLo;
    logic [ADDR_W-1:0] winHi;
  } ctrlStrobe_t;
endpackage

// File: rtl/wag_ctrl.sv
module wag_ctrl
  import wag_pkg::*;
#(
  parameter int unsigned DIM = 132
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic              parmValid,
  input  logic [ADDR_W-1:0] parmData,
  input  logic              pixValid,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DIM - 1);

  ctrlState_e        state, stateNext;
  logic [ADDR_W-1:0] firstByte;
  logic              pairLegal;

  assign pairLegal = (firstByte < parmData) && (parmData <= LAST);

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    strobe.winLo  = firstByte;
    strobe.winHi  = parmData;
    if (cmdValid) begin
      unique case (cmdCode)
        OP_COL_WIN:  stateNext = ST_COL_A;
        OP_PAGE_WIN: stateNext = ST_PAGE_A;
        OP_MEM_WR: begin
          stateNext     = ST_WRITE;
          strobe.rewind = 1'b1;
        end
        default:     stateNext = ST_IDLE;
      endcase
    end else begin
      unique case (state)
        ST_COL_A:  if (parmValid) stateNext = ST_COL_B;
        ST_PAGE_A: if (parmValid) stateNext = ST_PAGE_B;
        ST_COL_B: if (parmValid) begin
          stateNext         = ST_IDLE;
          strobe.loadWin[0] = pairLegal;
        end
        ST_PAGE_B: if (parmValid) begin
          stateNext         = ST_IDLE;
          strobe.loadWin[1] = pairLegal;
        end
        ST_WRITE:  strobe.step = pixValid;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstByte <= '0;
    end else begin
      state <= stateNext;
      if (!cmdValid && parmValid && (state == ST_COL_A || state == ST_PAGE_A))
        firstByte <= parmData;
    end
  end

  AST_CMD_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode != OP_MEM_WR) |=> (state != ST_WRITE)); // R7

  AST_PIX_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_WRITE) |-> !strobe.step); // R1
endmodule

// File: rtl/wag_axis.sv
module wag_axis
  import wag_pkg::*;
#(
  parameter int unsigned RST_LO = 2,
  parameter int unsigned RST_HI = 129
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              rewind,
  input  logic              advance,
  input  logic [ADDR_W-1:0] winLo,
  input  logic [ADDR_W-1:0] winHi,
  output logic [ADDR_W-1:0] ptr,
  output logic              atEnd
);
  logic [ADDR_W-1:0] lo, hi;

  assign atEnd = (ptr == hi);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lo  <= ADDR_W'(RST_LO);
      hi  <= ADDR_W'(RST_HI);
      ptr <= ADDR_W'(RST_LO);
    end else begin
      if (load) begin
        lo <= winLo;
        hi <= winHi;
      end
      if (rewind)       ptr <= lo;
      else if (advance) ptr <= atEnd ? lo : ptr + 1'b1;
    end
  end

  AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    lo < hi); // R2, R3

  AST_REWIND_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    (rewind && !load) |=> (ptr == lo)); // R4
endmodule

// File: rtl/wag_dpath.sv
module wag_dpath
  import wag_pkg::*;
#(
  parameter int unsigned DIM    = 132,
  parameter int unsigned RST_LO = 2,
  parameter int unsigned RST_HI = 129
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              dirPageFirst,
  input  logic              mirrorCol,
  input  logic              mirrorRow,
  output logic [ADDR_W-1:0] ramCol,
  output logic [ADDR_W-1:0] ramRow,
  output logic              ramWe
);
  localparam int unsigned  AXES = 2;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DIM - 1);

  logic [AXES-1:0][ADDR_W-1:0] ptr, phys;
  logic [AXES-1:0]             atEnd, adv, mirror;

  assign mirror = {mirrorRow, mirrorCol};
  // the slow axis moves only when the fast axis wraps
  assign adv[0] = strobe.step && (!dirPageFirst || atEnd[1]);
  assign adv[1] = strobe.step && ( dirPageFirst || atEnd[0]);

  for (genvar g = 0; g < AXES; g++) begin : gAxis
    wag_axis #(
      .RST_LO(RST_LO),
      .RST_HI(RST_HI)
    ) uAxis (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.loadWin[g]),
      .rewind (strobe.rewind),
      .advance(adv[g]),
      .winLo  (strobe.winLo),
      .winHi  (strobe.winHi),
      .ptr    (ptr[g]),
      .atEnd  (atEnd[g])
    );
    assign phys[g] = mirror[g] ? (LAST - ptr[g]) : ptr[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramCol <= '0;
      ramRow <= '0;
      ramWe  <= 1'b0;
    end else begin
      ramWe <= strobe.step;
      if (strobe.step) begin
        ramCol <= phys[0];
        ramRow <= phys[1];
      end
    end
  end

  AST_ONE_AXIS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (adv[0] || adv[1])); // R5
endmodule

// File: rtl/wag_top.sv
module wag_top
  import wag_pkg::*;
#(
  parameter int unsigned DIM    = 132,
  parameter int unsigned RST_LO = 2,
  parameter int unsigned RST_HI = 129
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       parmValid,
  input  logic [7:0] parmData,
  input  logic       pixValid,
  input  logic       dirPageFirst,
  input  logic       mirrorCol,
  input  logic       mirrorRow,
  output logic [7:0] ramCol,
  output logic [7:0] ramRow,
  output logic       ramWe
);
  ctrlStrobe_t strobe;

  wag_ctrl #(.DIM(DIM)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .parmValid(parmValid),
    .parmData (parmData),
    .pixValid (pixValid),
    .strobe   (strobe)
  );

  wag_dpath #(.DIM(DIM), .RST_LO(RST_LO), .RST_HI(RST_HI)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dirPageFirst(dirPageFirst),
    .mirrorCol   (mirrorCol),
    .mirrorRow   (mirrorRow),
    .ramCol      (ramCol),
    .ramRow      (ramRow),
    .ramWe       (ramWe)
  );

  AST_CMD_BLOCKS_PIXEL: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid) |-> !ramWe); // R8

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramCol < 8'(DIM) && ramRow < 8'(DIM))); // R9
endmodule

// File: tb/wag_top_test.sv
`timescale 1ns/1ps
module wag_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic       parmValid = 1'b0;
  logic [7:0] parmData = '0;
  logic       pixValid = 1'b0;
  logic       dirPageFirst = 1'b0;
  logic       mirrorCol = 1'b0;
  logic       mirrorRow = 1'b0;
  logic [7:0] ramCol, ramRow;
  logic       ramWe;

  int total = 0;
  int bad = 0;
  int cs, ce, ps, pe;

  always #2.5 clk = ~clk;

  wag_top uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .parmValid(parmValid), .parmData(parmData), .pixValid(pixValid),
    .dirPageFirst(dirPageFirst), .mirrorCol(mirrorCol), .mirrorRow(mirrorRow),
    .ramCol(ramCol), .ramRow(ramRow), .ramWe(ramWe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phys(input int x, input bit m);
    return m ? 131 - x : x;
  endfunction

  task automatic sendCmd(input logic [7:0] code);
    @(negedge clk); cmdValid = 1'b1; cmdCode = code;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendParm(input int b);
    @(negedge clk); parmValid = 1'b1; parmData = 8'(b);
    @(negedge clk); parmValid = 1'b0;
  endtask

  task automatic setWin(input logic [7:0] code, input int a, input int b);
    sendCmd(code); sendParm(a); sendParm(b);
  endtask

  // one pixel; the write appears one cycle later, sampled on the next falling edge
  task automatic pix(input string req, input bit expWe, input int expC, input int expR);
    @(negedge clk); pixValid = 1'b1;
    @(negedge clk); pixValid = 1'b0;
    chk(req, int'(ramWe), int'(expWe));
    if (expWe) begin
      chk(req, int'(ramCol), expC);
      chk(req, int'(ramRow), expR);
    end
  endtask

  // walk n pixels from the window corner and compare each address
  task automatic walk(input string req, input int n);
    int w, h, c, p;
    w = ce - cs + 1;
    h = pe - ps + 1;
    sendCmd(8'h2C);
    for (int k = 0; k < n; k++) begin
      if (!dirPageFirst) begin
        c = cs + k % w;
        p = ps + (k / w) % h;
      end else begin
        p = ps + k % h;
        c = cs + (k / h) % w;
      end
      pix(req, 1'b1, phys(c, mirrorCol), phys(p, mirrorRow));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset write enable", int'(ramWe), 0);
    pix("R1 pixel before write command", 1'b0, 0, 0);

    // reset window 2..129 walked with a wrap into the next page
    cs = 2; ce = 129; ps = 2; pe = 129;
    walk("R1 R4 R5 reset window walk", 130);

    // sweep windows, directions and mirrors
    for (int wsel = 0; wsel < 3; wsel++) begin
      case (wsel)
        0: begin cs = 5;   ce = 8;   ps = 10;  pe = 12;  end
        1: begin cs = 0;   ce = 1;   ps = 130; pe = 131; end
        default: begin cs = 127; ce = 131; ps = 0; pe = 3; end
      endcase
      setWin(8'h2A, cs, ce);
      setWin(8'h2B, ps, pe);
      for (int cfg = 0; cfg < 8; cfg++) begin
        dirPageFirst = cfg[0];
        mirrorCol    = cfg[1];
        mirrorRow    = cfg[2];
        if (!cfg[0]) walk("R2 R3 R5 R9 column-first sweep", (ce-cs+1)*(pe-ps+1) + 3);
        else         walk("R2 R3 R6 R9 page-first sweep", (ce-cs+1)*(pe-ps+1) + 3);
      end
    end
    dirPageFirst = 1'b0; mirrorCol = 1'b0; mirrorRow = 1'b0;

    // window 3..6 x 20..21 as a baseline
    cs = 3; ce = 6; ps = 20; pe = 21;
    setWin(8'h2A, cs, ce);
    setWin(8'h2B, ps, pe);
    // illegal pairs are rejected (R2 R3)
    setWin(8'h2A, 9, 4);
    setWin(8'h2A, 140, 150);
    setWin(8'h2B, 7, 7);
    setWin(8'h2B, 10, 132);
    walk("R2 R3 illegal window kept old", 9);

    // interrupted window command and stray parameter bytes (R10)
    sendCmd(8'h2A); sendParm(50); sendCmd(8'h00);
    sendParm(60); sendParm(70);
    setWin(8'h2B, 40, 41); sendParm(1);
    ps = 40; pe = 41;
    walk("R10 interrupted and stray bytes", 9);

    // NOP and another command end the burst (R7)
    sendCmd(8'h00);
    pix("R7 pixel after NOP", 1'b0, 0, 0);
    sendCmd(8'h2C);
    pix("R4 rewind after NOP", 1'b1, cs, ps);
    sendCmd(8'h13);
    pix("R7 pixel after other command", 1'b0, 0, 0);

    // command and pixel in the same cycle (R8)
    sendCmd(8'h2C);
    pix("R4 burst start", 1'b1, cs, ps);
    pix("R4 burst step", 1'b1, cs + 1, ps);
    @(negedge clk); cmdValid = 1'b1; cmdCode = 8'h2C; pixValid = 1'b1;
    @(negedge clk); cmdValid = 1'b0; pixValid = 1'b0;
    chk("R8 pixel dropped on rewind command", int'(ramWe), 0);
    pix("R8 R4 next pixel at corner", 1'b1, cs, ps);
    @(negedge clk); cmdValid = 1'b1; cmdCode = 8'h00; pixValid = 1'b1;
    @(negedge clk); cmdValid = 1'b0; pixValid = 1'b0;
    chk("R8 pixel dropped on NOP", int'(ramWe), 0);
    pix("R8 R7 burst ended", 1'b0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule